// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block keeps a running count of the slots already taken in the current dispatch group of a superscalar front end. Each cycle it looks at one pre-classified candidate instruction and reports one of three codes. The candidate may join the group now, it must wait for a fresh group (stall), or a no-op must be placed ahead of it. Opcode decoding and memory address overlap checks are done elsewhere. The candidate arrives as a unit class plus a few flag bits.

A scheduler presents a candidate, reads the hazard code, and pulses the issue strobe when it commits the candidate. When nothing is sent in a cycle, it pulses the advance strobe. The group closes when its slot count reaches five. A branch or a single-flagged instruction closes the group early. Closing the group clears the per-group record of a count-register write.

Top module: `dgrp_slot_guard`

## Requirements
- R1: After a synchronous active-low reset, the slot count is 0, the overflow flag is 0, and a plain fixed-point candidate gets hazard 0.
- R2: The unit class codes are 0 pseudo, 1 fixed-point, 2 load/store, 3 floating, 4 vector ALU, 5 vector permute, 6 condition-register and 7 branch. The hazard codes are 0 none, 1 stall and 2 noop. A pseudo candidate always gets hazard 0, whatever its flags. Issuing a pseudo changes neither the slot count nor the count-register record.
- R3: A candidate flagged first-only or single gets a stall whenever the slot count is not 0. At count 0 it is allowed.
- R4: A cracked candidate gets a stall when more than two slots are used. Issuing it adds two to the count.
- R5: With four slots used, every class except branch and condition-register gets a stall. A branch is still allowed in the last slot.
- R6: A condition-register candidate gets a stall when two or more slots are used.
- R7: Issuing a branch or a single-flagged instruction closes the group. The slot count is 0 in the next cycle.
- R8: Issuing any other non-pseudo instruction adds one slot, or two if it is cracked. Reaching five slots closes the group and returns the count to 0.
- R9: An advance strobe with no issue adds one slot. When that makes five, the group closes.
- R10: Issuing an instruction flagged as a count-register write sets a per-group record. While the record is set, a candidate marked as an indirect branch through that register gets hazard 2. Closing the group clears the record.
- R11: When several rules apply, the first in this order decides: pseudo, then first-only/single, then cracked, then the slot-position rules, then the noop rule.
- R12: Issue and advance in the same cycle apply the issue first. If the issue alone closes the group, the overflow flag is 1 in that cycle and the group still restarts at count 0. Otherwise the advance adds one more slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_unit | input | 3 | Candidate unit class code |
| cand_first_only | input | 1 | Candidate must start a group |
| cand_single | input | 1 | Candidate must start a group and fills it |
| cand_cracked | input | 1 | Candidate splits into two slots |
| cand_ctr_branch | input | 1 | Candidate branches indirectly through the count register |
| issue | input | 1 | The candidate is committed this cycle |
| issue_writes_ctr | input | 1 | The committed instruction writes the count register |
| advance | input | 1 | Empty cycle: consume one slot |
| hazard | output | 2 | Hazard code for the current candidate |
| slot_count | output | 3 | Slots used in the current group |
| adv_overflow | output | 1 | Advance arrived on a group that the same-cycle issue already filled |

## Verification
A wrong slot count shows up in the hazard code of the very next candidate whose legality depends on position. A misplaced stall on a condition-register, cracked or first-only candidate is visible within one cycle. A count-register record that is not cleared shows up as a noop on the first indirect branch in the following group. A record that is never set shows up as hazard 0 where 2 is due. Every such error is visible at the ports within one or two cycles of the issue or advance that caused it.

// File: rtl/dgrp_pkg.sv
// Shared encodings for the dispatch group slot hazard checker.
// Assumes unit class and hazard codes are fixed by the scheduler interface.
package dgrp_pkg;

    typedef enum logic [2:0] {
        UC_PSEUDO   = 3'd0,
        UC_FIXED    = 3'd1,
        UC_LDST     = 3'd2,
        UC_FLOAT    = 3'd3,
        UC_VEC_ALU  = 3'd4,
        UC_VEC_PERM = 3'd5,
        UC_CONDREG  = 3'd6,
        UC_BRANCH   = 3'd7
    } unit_class_e;

    typedef enum logic [1:0] {
        HZ_NONE  = 2'd0,
        HZ_STALL = 2'd1,
        HZ_NOOP  = 2'd2
    } hazard_e;

    typedef struct packed {
        unit_class_e unit;
        logic        first_only;
        logic        single;
        logic        cracked;
        logic        ctr_branch;
    } cand_t;

endpackage

// File: rtl/dgrp_hazard_eval.sv
// Combinational hazard decision for one candidate.
// Assumes slot_cnt is always below SLOTS; rules are tried in priority order.
module dgrp_hazard_eval
    import dgrp_pkg::*;
#(
    parameter int SLOTS    = 5,
    parameter int CR_LIMIT = 2,
    parameter int CNT_W    = 3
) (
    input  cand_t            cand,
    input  logic [CNT_W-1:0] slot_cnt,
    input  logic             ctr_set,
    output hazard_e          hazard
);

    localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] CRACK_MAX = CNT_W'(SLOTS - 3);
    localparam logic [CNT_W-1:0] CR_MIN    = CNT_W'(CR_LIMIT);

    logic is_pseudo;
    logic start_only;
    logic crack_late;
    logic pos_blocked;

    // Classify the candidate against the current slot position.
    always_comb begin
        is_pseudo   = (cand.unit == UC_PSEUDO);
        start_only  = (cand.first_only || cand.single) && (slot_cnt != '0);
        crack_late  = cand.cracked && (slot_cnt > CRACK_MAX);
        pos_blocked = 1'b0;
        case (cand.unit)
            UC_BRANCH:  pos_blocked = 1'b0;
            UC_CONDREG: pos_blocked = (slot_cnt >= CR_MIN);
            default:    pos_blocked = (slot_cnt == LAST_IDX);
        endcase
    end

    // Pick the first matching rule in priority order.
    always_comb begin
        if (is_pseudo) begin
            hazard = HZ_NONE;
        end else if (start_only) begin
            hazard = HZ_STALL;
        end else if (crack_late) begin
            hazard = HZ_STALL;
        end else if (pos_blocked) begin
            hazard = HZ_STALL;
        end else if (ctr_set && cand.ctr_branch) begin
            hazard = HZ_NOOP;
        end else begin
            hazard = HZ_NONE;
        end
    end

endmodule

// File: rtl/dgrp_slot_next.sv
// Next-state arithmetic for the group slot count and count-register record.
// Assumes the issue is applied before a same-cycle advance.
module dgrp_slot_next
    import dgrp_pkg::*;
#(
    parameter int SLOTS = 5,
    parameter int CNT_W = 3
) (
    input  cand_t            cand,
    input  logic             issue,
    input  logic             issue_writes_ctr,
    input  logic             advance,
    input  logic [CNT_W-1:0] slot_cnt,
    input  logic             ctr_set,
    output logic [CNT_W-1:0] slot_cnt_nxt,
    output logic             ctr_set_nxt,
    output logic             adv_overflow
);

    localparam int CALC_W = CNT_W + 1;
    localparam logic [CALC_W-1:0] LIMIT    = CALC_W'(SLOTS);
    localparam logic [CALC_W-1:0] LAST_IDX = CALC_W'(SLOTS - 1);

    logic              do_issue;
    logic [CALC_W-1:0] base;
    logic [CALC_W-1:0] after_issue;
    logic              issue_closes;
    logic [CALC_W-1:0] mid;
    logic [CALC_W-1:0] after_adv;
    logic              adv_closes;
    logic              group_end;

    // Apply the issue step: forced close for branch/single, then the slot cost.
    always_comb begin
        do_issue = issue && (cand.unit != UC_PSEUDO);
        base     = ((cand.unit == UC_BRANCH) || cand.single) ? LAST_IDX
                                                             : CALC_W'(slot_cnt);
        after_issue  = do_issue ? (base + CALC_W'(1) + CALC_W'(cand.cracked))
                                : CALC_W'(slot_cnt);
        issue_closes = do_issue && (after_issue >= LIMIT);
        mid          = issue_closes ? '0 : after_issue;
    end

    // Apply the advance step on top of the issue result.
    always_comb begin
        adv_overflow = advance && issue_closes;
        after_adv    = (advance && !issue_closes) ? (mid + CALC_W'(1)) : mid;
        adv_closes   = advance && !issue_closes && (after_adv >= LIMIT);
        group_end    = issue_closes || adv_closes;
    end

    // Form the next registered values.
    always_comb begin
        slot_cnt_nxt = group_end ? '0 : after_adv[CNT_W-1:0];
        ctr_set_nxt  = group_end ? 1'b0 : (ctr_set || (do_issue && issue_writes_ctr));
    end

endmodule

// File: rtl/dgrp_group_state.sv
// Registers holding the slot count and the count-register record.
// Assumes a synchronous active-low reset.
module dgrp_group_state #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] slot_cnt_nxt,
    input  logic             ctr_set_nxt,
    output logic [CNT_W-1:0] slot_cnt,
    output logic             ctr_set
);

    // Hold the per-group state from cycle to cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            ctr_set  <= 1'b0;
        end else begin
            slot_cnt <= slot_cnt_nxt;
            ctr_set  <= ctr_set_nxt;
        end
    end

endmodule

// File: rtl/dgrp_slot_guard.sv
// Top: dispatch group slot hazard checker.
// Reports the hazard for the presented candidate and tracks group slot usage.
// Assumes the candidate is already classified.
module dgrp_slot_guard
    import dgrp_pkg::*;
#(
    parameter  int SLOTS    = 5,
    parameter  int CR_LIMIT = 2,
    localparam int CNT_W    = $clog2(SLOTS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cand_unit,
    input  logic             cand_first_only,
    input  logic             cand_single,
    input  logic             cand_cracked,
    input  logic             cand_ctr_branch,
    input  logic             issue,
    input  logic             issue_writes_ctr,
    input  logic             advance,
    output logic [1:0]       hazard,
    output logic [CNT_W-1:0] slot_count,
    output logic             adv_overflow
);

    cand_t            cand;
    hazard_e          hz;
    logic [CNT_W-1:0] slot_cnt;
    logic [CNT_W-1:0] slot_cnt_nxt;
    logic             ctr_set;
    logic             ctr_set_nxt;

    // Pack the candidate fields into the shared type.
    always_comb begin
        cand.unit       = unit_class_e'(cand_unit);
        cand.first_only = cand_first_only;
        cand.single     = cand_single;
        cand.cracked    = cand_cracked;
        cand.ctr_branch = cand_ctr_branch;
    end

    dgrp_hazard_eval #(
        .SLOTS(SLOTS), .CR_LIMIT(CR_LIMIT), .CNT_W(CNT_W)
    ) u_eval (
        .cand(cand), .slot_cnt(slot_cnt), .ctr_set(ctr_set), .hazard(hz)
    );

    dgrp_slot_next #(
        .SLOTS(SLOTS), .CNT_W(CNT_W)
    ) u_next (
        .cand(cand), .issue(issue), .issue_writes_ctr(issue_writes_ctr),
        .advance(advance), .slot_cnt(slot_cnt), .ctr_set(ctr_set),
        .slot_cnt_nxt(slot_cnt_nxt), .ctr_set_nxt(ctr_set_nxt),
        .adv_overflow(adv_overflow)
    );

    dgrp_group_state #(
        .CNT_W(CNT_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .slot_cnt_nxt(slot_cnt_nxt),
        .ctr_set_nxt(ctr_set_nxt), .slot_cnt(slot_cnt), .ctr_set(ctr_set)
    );

    // Drive the outputs.
    always_comb begin
        hazard     = hz;
        slot_count = slot_cnt;
    end

endmodule

// File: rtl/dgrp_slot_guard_chk.sv
// Checker bound to the top; relates its ports over time.
module dgrp_slot_guard_chk #(
    parameter int SLOTS = 5,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cand_unit,
    input logic             cand_first_only,
    input logic             cand_single,
    input logic             cand_cracked,
    input logic             cand_ctr_branch,
    input logic             issue,
    input logic             advance,
    input logic [1:0]       hazard,
    input logic [CNT_W-1:0] slot_count,
    input logic             adv_overflow
);

    // R8
    slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot_count) < SLOTS);

    // R2
    pseudo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit == 3'd0) |-> (hazard == 2'd0));

    // R2
    pseudo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit == 3'd0 && !advance) |=> $stable(slot_count));

    // R3
    start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit != 3'd0 && (cand_first_only || cand_single) && slot_count != '0)
        |-> (hazard == 2'd1));

    // R6
    condreg_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_unit == 3'd6 && int'(slot_count) >= 2) |-> (hazard == 2'd1));

    // R7
    branch_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cand_unit == 3'd7 && !advance) |=> (slot_count == '0));

    // R10
    noop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard == 2'd2) |-> cand_ctr_branch);

    // R12
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_overflow |-> (advance && issue));

    // R12
    overflow_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_overflow |=> (slot_count == '0));

endmodule

bind dgrp_slot_guard dgrp_slot_guard_chk #(
    .SLOTS(SLOTS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cand_unit(cand_unit),
    .cand_first_only(cand_first_only), .cand_single(cand_single),
    .cand_cracked(cand_cracked), .cand_ctr_branch(cand_ctr_branch),
    .issue(issue), .advance(advance), .hazard(hazard),
    .slot_count(slot_count), .adv_overflow(adv_overflow)
);

// File: tb/dgrp_slot_guard_bench.sv
// Scoreboard bench: the driver pushes expected items, the monitor compares.
module dgrp_slot_guard_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cand_unit = 3'd0;
    logic       cand_first_only = 1'b0;
    logic       cand_single = 1'b0;
    logic       cand_cracked = 1'b0;
    logic       cand_ctr_branch = 1'b0;
    logic       issue = 1'b0;
    logic       issue_writes_ctr = 1'b0;
    logic       advance = 1'b0;
    logic [1:0] hazard;
    logic [2:0] slot_count;
    logic       adv_overflow;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int    haz;
        int    cnt;
        int    ovf;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    dgrp_slot_guard u_dgrp_slot_guard (
        .clk(clk), .rst_n(rst_n), .cand_unit(cand_unit),
        .cand_first_only(cand_first_only), .cand_single(cand_single),
        .cand_cracked(cand_cracked), .cand_ctr_branch(cand_ctr_branch),
        .issue(issue), .issue_writes_ctr(issue_writes_ctr), .advance(advance),
        .hazard(hazard), .slot_count(slot_count), .adv_overflow(adv_overflow)
    );

    // Driver: apply one cycle of stimulus and push its expected result.
    task automatic step(input int u, input int f, input int s, input int c,
                        input int cb, input int iss, input int wc, input int adv,
                        input int eh, input int ec, input int eo, input string tag);
        exp_item_t it;
        @(negedge clk);
        #1;
        cand_unit        = 3'(u);
        cand_first_only  = f[0];
        cand_single      = s[0];
        cand_cracked     = c[0];
        cand_ctr_branch  = cb[0];
        issue            = iss[0];
        issue_writes_ctr = wc[0];
        advance          = adv[0];
        it.haz = eh; it.cnt = ec; it.ovf = eo; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare outputs against queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_cmp += 3;
                if (int'(hazard) != it.haz) begin
                    n_bad++;
                    $display("FAIL %s hazard actual=%0d expected=%0d", it.tag, hazard, it.haz);
                end
                if (int'(slot_count) != it.cnt) begin
                    n_bad++;
                    $display("FAIL %s count actual=%0d expected=%0d", it.tag, slot_count, it.cnt);
                end
                if (int'(adv_overflow) != it.ovf) begin
                    n_bad++;
                    $display("FAIL %s overflow actual=%0d expected=%0d", it.tag, adv_overflow, it.ovf);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Stimulus: unit codes 1 fixed,2 ldst,3 float,4 vec alu,5 vec perm,6 condreg,7 branch.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //    u f s c cb iss wc adv  haz cnt ovf
        step(1,0,0,0,0, 0,0,0, 0,0,0, "R1 reset state");
        step(0,1,1,1,1, 1,0,0, 0,0,0, "R2 pseudo flags ignored");
        step(1,1,0,0,0, 0,0,0, 0,0,0, "R3 first-only at zero");
        step(1,0,0,0,0, 1,0,0, 0,0,0, "R8 fixed issue");
        step(1,1,0,0,0, 0,0,0, 1,1,0, "R3 first-only late");
        step(2,0,1,0,0, 0,0,0, 1,1,0, "R3 single late");
        step(6,0,0,0,0, 0,0,0, 0,1,0, "R6 condreg at one");
        step(6,0,0,0,0, 1,0,0, 0,1,0, "R6 condreg issue");
        step(6,0,0,0,0, 0,0,0, 1,2,0, "R6 condreg at two");
        step(3,0,0,1,0, 0,0,0, 0,2,0, "R4 cracked at two");
        step(3,0,0,1,0, 1,0,0, 0,2,0, "R4 cracked issue");
        step(4,0,0,0,0, 0,0,0, 1,4,0, "R5 vec alu at four");
        step(5,0,0,1,0, 0,0,0, 1,4,0, "R4 cracked at four");
        step(7,0,0,0,0, 0,0,0, 0,4,0, "R5 branch at four");
        step(7,0,0,0,0, 1,0,0, 0,4,0, "R5 branch issue");
        step(1,0,0,0,0, 0,0,0, 0,0,0, "R8 group closed");
        step(1,0,0,0,0, 1,0,0, 0,0,0, "R8 fixed issue");
        step(7,0,0,0,0, 1,0,0, 0,1,0, "R7 early branch");
        step(1,0,0,0,0, 0,0,0, 0,0,0, "R7 branch closed group");
        step(1,0,1,0,0, 1,0,0, 0,0,0, "R7 single issue");
        step(1,0,0,0,0, 0,0,0, 0,0,0, "R7 single closed group");
        step(1,0,0,0,0, 0,0,1, 0,0,0, "R9 advance 0");
        step(1,0,0,0,0, 0,0,1, 0,1,0, "R9 advance 1");
        step(1,0,0,0,0, 0,0,1, 0,2,0, "R9 advance 2");
        step(1,0,0,0,0, 0,0,1, 0,3,0, "R9 advance 3");
        step(1,0,0,0,0, 0,0,1, 1,4,0, "R9 advance 4");
        step(1,0,0,0,0, 0,0,0, 0,0,0, "R9 advance closed group");
        step(1,0,0,0,0, 1,1,0, 0,0,0, "R10 count write");
        step(7,0,0,0,1, 0,0,0, 2,1,0, "R10 indirect branch noop");
        step(7,1,0,0,1, 0,0,0, 1,1,0, "R11 stall beats noop");
        step(1,0,0,0,0, 1,0,0, 0,1,0, "R8 fill");
        step(1,0,0,0,0, 1,0,0, 0,2,0, "R8 fill");
        step(1,0,0,0,0, 1,0,0, 0,3,0, "R8 fill");
        step(7,0,0,0,0, 1,0,0, 0,4,0, "R8 close");
        step(7,0,0,0,1, 0,0,0, 0,0,0, "R10 record cleared");
        step(1,0,0,0,0, 1,1,0, 0,0,0, "R10 count write");
        step(0,0,0,0,1, 0,0,0, 0,1,0, "R11 pseudo beats noop");
        step(0,0,0,0,0, 1,1,0, 0,1,0, "R2 pseudo issue");
        step(1,0,0,0,0, 0,0,0, 0,1,0, "R2 pseudo kept count");
        step(1,0,0,0,0, 1,0,0, 0,1,0, "R8 fill");
        step(1,0,0,0,0, 1,0,0, 0,2,0, "R8 fill");
        step(1,0,0,1,0, 0,0,0, 1,3,0, "R4 cracked at three");
        step(6,0,0,0,0, 0,0,0, 1,3,0, "R6 condreg at three");
        step(1,0,0,0,0, 0,0,1, 0,3,0, "R9 advance 3");
        step(1,0,0,0,0, 0,0,1, 1,4,0, "R9 advance 4");
        step(7,0,0,0,1, 0,0,0, 0,0,0, "R10 cleared by advance close");
        step(1,0,0,0,0, 1,0,1, 0,0,0, "R12 issue then advance");
        step(1,0,0,0,0, 0,0,0, 0,2,0, "R12 both counted");
        step(7,0,0,0,0, 1,0,1, 0,2,1, "R12 overflow");
        step(1,0,0,0,0, 0,0,0, 0,0,0, "R12 group restarted");
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule